// File: doc/BRIEF.md
# Descriptor-Chain DMA Sequencer

This block is a single-channel DMA engine that works through a chain of descriptors stored in memory. Each descriptor names one source buffer. The engine reads the descriptor over a word-wide memory port, copies the buffer word by word to a destination that keeps running contiguously from the address software set before starting, writes the descriptor's first control word back with a completion flag, and then follows the next pointer. The chain ends at a descriptor whose control word carries the last marker, or whose next pointer is zero.

Software sets a global enable, the first descriptor address and the starting destination through a small register interface, then sets the channel enable. When the chain finishes, the channel enable drops by itself and a sticky completion flag is raised. Reading the status register clears that flag. The memory port issues one access per cycle at most. Read data comes back on the cycle after the request.

Top module: `ldma_top`

## Requirements
- R1: After reset, every readable register returns 0, and `mem_rd` and `mem_wr` are low.
- R2: A chain starts only when global register bit 0 and channel register bit 0 are both 1. While either is 0 and the engine is idle, no memory access occurs.
- R3: A descriptor is five 32-bit words at byte offsets 0, 4, 8, 12 and 16 from its base: source address, destination address, control A, control B, next pointer. They are read in that order, and the first descriptor's base is the value in the pointer register (offset 2).
- R4: The fetched destination word is never used. Writes start at the value in the destination register (offset 3) and continue from wherever the previous descriptor left off. The working destination can be read at offset 5.
- R5: The source address is reloaded from each descriptor. Control B bits [1:0] give the source step and bits [3:2] give the destination step: 00 adds 4, 01 subtracts 4, and 1x keeps the address fixed.
- R6: Control A bits [15:0] give the number of words to copy. A length of 0 copies nothing but still performs the write-back.
- R7: After each buffer, control A with bit 31 set is written to descriptor base + 8.
- R8: If control B bit 31 is 0 and the next pointer is non-zero, the next descriptor is fetched from that pointer. Otherwise the chain ends, and the next pointer is not followed.
- R9: At chain end, channel register bit 0 returns to 0 and status (offset 4) bit 0 is set. A read of status clears bit 0. Status bit 1 reads 1 while the engine is busy.
- R10: Writing 0 to channel register bit 0 has no effect; only the engine clears it.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears flag) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle as `reg_rd` |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
Register reads are combinational: the bench samples read data in the same cycle it raises the strobe, and the clear-on-read takes effect at the following edge. Descriptor and data reads take effect two cycles after they are issued, since the data returns one cycle late and is then captured. One descriptor therefore costs ten fetch cycles, three cycles per word and two closing cycles. The bench does not count those cycles. It polls the self-clearing channel bit, checks memory only after completion, and logs every read address at the clock edge where it is issued, so that fetch order can be compared. A sweep over all nine step-mode pairings compares the destination window against addresses computed in the bench.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
    localparam int DW      = 32;
    localparam int LEN_W   = 16;
    localparam int IDX_W   = 3;
    localparam int RAW     = 3;
    localparam int DONE_B  = 31;
    localparam int LAST_B  = 31;
    localparam int WORD_B  = 4;

    // descriptor word slots
    localparam int SLOT_SRC  = 0;
    localparam int SLOT_DST  = 1;
    localparam int SLOT_CTLA = 2;
    localparam int SLOT_CTLB = 3;
    localparam int SLOT_NEXT = 4;

    // address step encodings
    localparam logic [1:0] STEP_UP   = 2'b00;
    localparam logic [1:0] STEP_DOWN = 2'b01;

    // register indices
    localparam logic [RAW-1:0] RG_GLOBAL = 3'd0;
    localparam logic [RAW-1:0] RG_CHAN   = 3'd1;
    localparam logic [RAW-1:0] RG_DPTR   = 3'd2;
    localparam logic [RAW-1:0] RG_DSTINI = 3'd3;
    localparam logic [RAW-1:0] RG_STAT   = 3'd4;
    localparam logic [RAW-1:0] RG_DSTNOW = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FRD, ST_FCAP, ST_XRD, ST_XCAP, ST_XWR, ST_WB, ST_NEXT
    } seq_state_e;
endpackage

// File: rtl/ldma_addr_step.sv
module ldma_addr_step #(
    parameter int AW     = 32,
    parameter int STRIDE = 4
) (
    input  logic [AW-1:0] cur_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] nxt_o
);
    import ldma_pkg::*;

    always_comb begin
        case (mode_i)
            STEP_UP:   nxt_o = cur_i + AW'(STRIDE);
            STEP_DOWN: nxt_o = cur_i - AW'(STRIDE);
            default:   nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ldma_regs.sv
module ldma_regs #(
    parameter int DW  = 32,
    parameter int RAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic           rd_i,
    input  logic [RAW-1:0] addr_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o,
    input  logic           done_i,
    input  logic           busy_i,
    input  logic [DW-1:0]  dst_now_i,
    output logic           gen_o,
    output logic           chan_o,
    output logic [DW-1:0]  dptr_o,
    output logic [DW-1:0]  dst_o
);
    import ldma_pkg::*;

    typedef struct packed {
        logic          gen;
        logic          chan;
        logic          irq;
        logic [DW-1:0] dptr;
        logic [DW-1:0] dst;
    } reg_t;

    reg_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            case (addr_i)
                RG_GLOBAL: d.gen  = wdata_i[0];
                RG_CHAN:   if (wdata_i[0]) d.chan = 1'b1;
                RG_DPTR:   d.dptr = wdata_i;
                RG_DSTINI: d.dst  = wdata_i;
                default: ;
            endcase
        end
        if (rd_i && addr_i == RG_STAT) d.irq = 1'b0;
        if (done_i) begin
            d.chan = 1'b0;
            d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                RG_GLOBAL: rdata_o = DW'(q.gen);
                RG_CHAN:   rdata_o = DW'(q.chan);
                RG_DPTR:   rdata_o = q.dptr;
                RG_DSTINI: rdata_o = q.dst;
                RG_STAT:   rdata_o = DW'({busy_i, q.irq});
                RG_DSTNOW: rdata_o = dst_now_i;
                default:   rdata_o = '0;
            endcase
        end
    end

    assign gen_o  = q.gen;
    assign chan_o = q.chan;
    assign dptr_o = q.dptr;
    assign dst_o  = q.dst;

    // R9
    chan_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.chan) |-> $past(done_i));
    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> $past(done_i));
endmodule

// File: rtl/ldma_seq.sv
module ldma_seq #(
    parameter int DW    = 32,
    parameter int LEN_W = 16,
    parameter int IDX_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dptr_i,
    input  logic [DW-1:0] dst_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] dst_now_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i
);
    import ldma_pkg::*;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_NEXT);
    localparam logic [DW-1:0]    WB_OFS   = DW'(SLOT_CTLA * WORD_B);
    localparam logic [DW-1:0]    DONE_MSK = DW'(1) << DONE_B;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    base;
        logic [DW-1:0]    sa;
        logic [DW-1:0]    da;
        logic [DW-1:0]    ca;
        logic [DW-1:0]    nx;
        logic [DW-1:0]    data;
        logic [1:0]       smode;
        logic [1:0]       dmode;
        logic             last;
        logic [LEN_W-1:0] cnt;
    } seq_t;

    seq_t q, d;
    logic [DW-1:0] sa_step, da_step;

    ldma_addr_step #(.AW(DW), .STRIDE(WORD_B)) u_src_step (
        .cur_i(q.sa), .mode_i(q.smode), .nxt_o(sa_step));
    ldma_addr_step #(.AW(DW), .STRIDE(WORD_B)) u_dst_step (
        .cur_i(q.da), .mode_i(q.dmode), .nxt_o(da_step));

    always_comb begin
        d           = q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        done_o      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.base = dptr_i;
                    d.da   = dst_i;
                    d.idx  = '0;
                    d.st   = ST_FRD;
                end
            end
            ST_FRD: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = q.base + (DW'(q.idx) << 2);
                d.st       = ST_FCAP;
            end
            ST_FCAP: begin
                case (q.idx)
                    IDX_W'(SLOT_SRC):  d.sa = mem_rdata_i;
                    IDX_W'(SLOT_CTLA): d.ca = mem_rdata_i;
                    IDX_W'(SLOT_CTLB): begin
                        d.smode = mem_rdata_i[1:0];
                        d.dmode = mem_rdata_i[3:2];
                        d.last  = mem_rdata_i[LAST_B];
                    end
                    IDX_W'(SLOT_NEXT): d.nx = mem_rdata_i;
                    default: ;  // destination slot is discarded
                endcase
                if (q.idx == IDX_LAST) begin
                    d.cnt = q.ca[LEN_W-1:0];
                    d.st  = (q.ca[LEN_W-1:0] == '0) ? ST_WB : ST_XRD;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_FRD;
                end
            end
            ST_XRD: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = q.sa;
                d.st       = ST_XCAP;
            end
            ST_XCAP: begin
                d.data = mem_rdata_i;
                d.st   = ST_XWR;
            end
            ST_XWR: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = q.da;
                mem_wdata_o = q.data;
                d.sa        = sa_step;
                d.da        = da_step;
                d.cnt       = q.cnt - 1'b1;
                d.st        = (q.cnt == LEN_W'(1)) ? ST_WB : ST_XRD;
            end
            ST_WB: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = q.base + WB_OFS;
                mem_wdata_o = q.ca | DONE_MSK;
                d.st        = ST_NEXT;
            end
            ST_NEXT: begin
                if (q.last || q.nx == '0) begin
                    done_o = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.base = q.nx;
                    d.idx  = '0;
                    d.st   = ST_FRD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign dst_now_o = q.da;

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    // R6
    xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XRD) |-> (q.cnt != '0));
    // R3
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FCAP && q.idx != IDX_LAST) |=>
            (mem_rd_o && mem_addr_o == $past(mem_addr_o, 2) + DW'(WORD_B)));
    // R8
    follow_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_NEXT && !q.last && q.nx != '0) |=>
            (mem_rd_o && mem_addr_o == $past(q.nx)));
endmodule

// File: rtl/ldma_top.sv
module ldma_top #(
    parameter int DW    = ldma_pkg::DW,
    parameter int LEN_W = ldma_pkg::LEN_W,
    parameter int RAW   = ldma_pkg::RAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);
    import ldma_pkg::*;

    logic          gen, chan, busy, done, start;
    logic [DW-1:0] dptr, dst_ini, dst_now;

    ldma_regs #(.DW(DW), .RAW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .done_i(done), .busy_i(busy), .dst_now_i(dst_now),
        .gen_o(gen), .chan_o(chan), .dptr_o(dptr), .dst_o(dst_ini));

    assign start = gen && chan && !busy;

    ldma_seq #(.DW(DW), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .dptr_i(dptr), .dst_i(dst_ini),
        .busy_o(busy), .done_o(done), .dst_now_o(dst_now),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gen && chan));
endmodule

// File: tb/ldma_top_test.sv
module ldma_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:1023];
    logic [31:0] rlog [0:31];
    int          rlog_n = 0;
    logic        rlog_clr = 1'b0;
    int          tests = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldma_top uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
        if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (rlog_clr) rlog_n <= 0;
        else if (mem_rd && rlog_n < 32) begin
            rlog[rlog_n] <= mem_addr;
            rlog_n <= rlog_n + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_CYC) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WDOG_CYC);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a, input int salt);
        return 32'h5A00_0000 ^ a ^ (32'(salt) << 16);
    endfunction

    function automatic logic [31:0] step(input logic [31:0] a, input int m);
        if (m == 0) return a + 32'd4;
        if (m == 1) return a - 32'd4;
        return a;
    endfunction

    task automatic put_desc(input logic [31:0] b, input logic [31:0] sa,
                            input logic [31:0] ca, input logic [31:0] cb,
                            input logic [31:0] nx);
        mem[b[11:2]]     = sa;
        mem[b[11:2] + 1] = 32'hDEAD_0000;
        mem[b[11:2] + 2] = ca;
        mem[b[11:2] + 3] = cb;
        mem[b[11:2] + 4] = nx;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            reg_read(3'd1, v);
            if (v[0] == 1'b0) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] e [0:15];
        bit ok;
        int rd_before;

        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
        check("R1 mem_wr", {31'b0, mem_wr}, 32'd0);
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), v);
            check("R1 register", v, 32'd0);
        end

        // chain: d0 len2 up/up, d1 len0, d2 len2 src down last, d3 never reached
        for (int i = 0; i < 8; i++) mem[(32'h400 >> 2) + i] = pat(32'h400 + 32'(4*i), 1);
        for (int i = 0; i < 8; i++) mem[(32'h5F0 >> 2) + i] = pat(32'h5F0 + 32'(4*i), 1);
        put_desc(32'h100, 32'h400, 32'd2, 32'h0, 32'h140);
        put_desc(32'h140, 32'h500, 32'd0, 32'h0, 32'h180);
        put_desc(32'h180, 32'h600, 32'd2, 32'h8000_0001, 32'h1C0);
        put_desc(32'h1C0, 32'h400, 32'd5, 32'h0, 32'h0);

        reg_write(3'd2, 32'h100);
        reg_write(3'd3, 32'h800);
        @(negedge clk); rlog_clr = 1'b1; @(negedge clk); rlog_clr = 1'b0;
        reg_write(3'd1, 32'd1);
        repeat (10) @(negedge clk);
        // R2 channel alone does not start
        check("R2 no access without global enable", 32'(rlog_n), 32'd0);
        reg_read(3'd4, v);
        check("R2 idle status", v, 32'd0);
        // R10 writing 0 to channel bit is ignored
        reg_write(3'd1, 32'd0);
        reg_read(3'd1, v);
        check("R10 channel bit held", v, 32'd1);
        rd_before = rlog_n;
        check("R2 still no access", 32'(rd_before), 32'd0);
        reg_write(3'd0, 32'd1);
        @(negedge clk);
        reg_read(3'd4, v);
        check("R9 busy flag while running", {30'b0, v[1:0]}, 32'd2);
        wait_done(ok);
        check("R9 channel self-clear", {31'b0, ok}, 32'd1);

        // R3 fetch order
        for (int i = 0; i < 5; i++) check("R3 first descriptor read", rlog[i], 32'h100 + 32'(4*i));
        check("R5 src from d0", rlog[5], 32'h400);
        check("R5 src up", rlog[6], 32'h404);
        for (int i = 0; i < 5; i++) check("R8 second descriptor read", rlog[7+i], 32'h140 + 32'(4*i));
        for (int i = 0; i < 5; i++) check("R8 third descriptor read", rlog[12+i], 32'h180 + 32'(4*i));
        check("R5 src reload d2", rlog[17], 32'h600);
        check("R5 src down", rlog[18], 32'h5FC);
        check("R8 chain stopped at last marker", 32'(rlog_n), 32'd19);
        // R4 contiguous destination, descriptor dst word ignored
        check("R4 dst word0", mem[32'h800 >> 2], pat(32'h400, 1));
        check("R4 dst word1", mem[32'h804 >> 2], pat(32'h404, 1));
        check("R4 dst word2", mem[32'h808 >> 2], mem[32'h600 >> 2]);
        check("R4 dst word3", mem[32'h80C >> 2], mem[32'h5FC >> 2]);
        check("R4 dst beyond end", mem[32'h810 >> 2], 32'd0);
        check("R4 fetched dst unused", mem[0], 32'd0);
        reg_read(3'd5, v);
        check("R4 working dst", v, 32'h810);
        // R6 R7 write-backs
        check("R7 wb d0", mem[32'h108 >> 2], 32'h8000_0002);
        check("R6 zero length wb d1", mem[32'h148 >> 2], 32'h8000_0000);
        check("R7 wb d2", mem[32'h188 >> 2], 32'h8000_0002);
        check("R8 unreached descriptor untouched", mem[32'h1C8 >> 2], 32'd5);
        // R9 sticky flag and clear on read
        reg_read(3'd4, v);
        check("R9 status set", v, 32'd1);
        reg_read(3'd4, v);
        check("R9 status cleared by read", v, 32'd0);

        // R5 sweep over all step pairings, single descriptor ending by null pointer
        for (int sm = 0; sm < 3; sm++) begin
            for (int dm = 0; dm < 3; dm++) begin
                logic [31:0] s, dd;
                int salt;
                salt = 10 + sm * 3 + dm;
                for (int i = 0; i < 16; i++) mem[(32'h3E0 >> 2) + i] = pat(32'h3E0 + 32'(4*i), salt);
                for (int i = 0; i < 16; i++) begin
                    mem[(32'h860 >> 2) + i] = '0;
                    e[i] = '0;
                end
                put_desc(32'h200, 32'h400, 32'd3, {28'b0, 2'(dm), 2'(sm)}, 32'h0);
                s = 32'h400; dd = 32'h880;
                for (int k = 0; k < 3; k++) begin
                    e[(dd - 32'h860) >> 2] = pat(s, salt);
                    s = step(s, sm);
                    dd = step(dd, dm);
                end
                reg_write(3'd2, 32'h200);
                reg_write(3'd3, 32'h880);
                reg_write(3'd1, 32'd1);
                wait_done(ok);
                check("R5 sweep completion", {31'b0, ok}, 32'd1);
                for (int i = 0; i < 16; i++)
                    check($sformatf("R5 sweep s%0d d%0d word %0d", sm, dm, i),
                          mem[(32'h860 >> 2) + i], e[i]);
                reg_read(3'd5, v);
                check("R5 sweep final dst", v, dd);
                check("R7 sweep wb", mem[32'h208 >> 2], 32'h8000_0003);
                reg_read(3'd4, v);
                check("R9 sweep status", v, 32'd1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule